// File: doc/BRIEF.md
# Triggered Parallel-to-Serial Transfer Controller

This block is an SPI-style master that starts a transfer on its own when a hardware trigger input shows a chosen edge, with no software command. When the edge is seen, the block loads one data word into its shift register. The word is either a snapshot of a parallel input bus, taken in the same clock as the edge is detected, or the contents of an alternate word register that host software writes. It then clocks the word out MSB first in SPI mode 0 and collects the MISO bits into the same register. At the end it raises a one-clock done pulse with the received word.

A small configuration register holds three settings. The first picks the trigger edge. The second picks the data source. The third enables a chained mode, in which the transfer length is a programmed SCK count instead of the frame size. In chained mode, several devices in a daisy chain can be served by one transfer: after the word has gone out, the block forwards on MOSI whatever it has already received on MISO.

The controller is built around five states:
- `ST_IDLE`: waits for a trigger edge.
- `ST_LEAD`: asserts chip select for one clock.
- `ST_SHIFT`: runs four clocks per bit, SCK high for two and low for two.
- `ST_TRAIL`: holds chip select for one clock after the last falling SCK edge.
- `ST_DONE`: releases chip select and pulses done.

The transitions are:
- IDLE→LEAD on a trigger edge.
- LEAD→SHIFT unconditionally.
- SHIFT→SHIFT while bits remain.
- SHIFT→TRAIL at the falling edge of the last bit.
- TRAIL→DONE unconditionally.
- DONE→IDLE unconditionally.

Top module: `trig_ser_ctrl`

## Requirements
- R1: After reset, `cfg_rd` reads 0, `cs_n` is 1, and `sck`, `busy` and `done` are 0. The configuration layout, for both `cfg_wdata` and `cfg_rd`, is: bit 0 trigger polarity, bit 1 data source, bit 2 chain enable, bits CNT_W+2:3 chain count. When idle, a write pulse on `cfg_we` stores `cfg_wdata`, and `cfg_rd` shows it from the next clock.
- R2: A configuration write while `busy` is 1 is dropped, and `cfg_rd` keeps its old value.
- R3: With polarity 0, only a falling edge of `trig_in` starts a transfer; with polarity 1, only a rising edge does. An edge of the other direction starts nothing.
- R4: `trig_in` passes through a two-flop synchronizer. `cs_n` goes low on the third rising clock edge after `trig_in` changes to its active level.
- R5: With data source 0, the word sent is the value of `par_in` in the clock where the edge is detected; later changes of `par_in` have no effect on the transfer.
- R6: With data source 1, the word sent is the alternate register. An `alt_we` write in the very clock where the edge is detected does not reach that transfer; the old contents are sent.
- R7: With chain enable 0, exactly FRAME_W SCK pulses are produced, each high for two clocks and low for two. MOSI carries the word MSB first and is stable on each rising SCK edge (mode 0).
- R8: With chain enable 1, the number of SCK pulses is the count field plus one, but never fewer than FRAME_W. MOSI carries the word first, then the MISO bits in the order received.
- R9: `cs_n` is low exactly one clock before the first rising SCK edge, and returns high exactly one clock after the last falling SCK edge.
- R10: `done` is a one-clock pulse in the clock where `cs_n` returns high. `rx_data` then holds the last FRAME_W MISO bits sampled, with the earliest of them at the MSB.
- R11: Trigger edges that arrive while `busy` is 1 are ignored. A transfer only begins from idle, and each active edge in idle gives exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Hardware trigger, asynchronous |
| par_in | input | FRAME_W | Parallel pins captured at trigger detection |
| alt_we | input | 1 | Write strobe for the alternate word register |
| alt_wdata | input | FRAME_W | Alternate word write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CNT_W+3 | Configuration write data |
| cfg_rd | output | CNT_W+3 | Current configuration |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | High from chip-select assertion through the done clock |
| done | output | 1 | One-clock end-of-transfer pulse |
| rx_data | output | FRAME_W | Received word, valid with done |

## Verification
Two events can land in the same clock and need a defined outcome:
- A software write to the alternate register and the trigger-edge detection that loads the shift register. The bench times an `alt_we` pulse so that it is sampled on the exact clock that loads the word. It then requires that the old register contents appear on MOSI.
- A configuration write and a running transfer. The bench writes the configuration while `busy` is 1 and requires `cfg_rd` to be unchanged.

The bench also re-fires the trigger mid-transfer and counts chip-select assertions, which must come to exactly one.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3,
        ST_DONE  = 3'd4
    } tsc_state_e;

    // configuration field positions
    localparam int CFG_TPOL_BIT  = 0;
    localparam int CFG_SRC_BIT   = 1;
    localparam int CFG_CHAIN_BIT = 2;
    localparam int CFG_CNT_LSB   = 3;

endpackage

// File: rtl/tsc_trig_edge.sv
module tsc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic pol_rise,
    output logic hit
);
    logic sync1_q, sync2_q, hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
        end else begin
            sync1_q <= trig_in;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
        end
    end

    logic rise_seen, fall_seen;
    assign rise_seen = sync2_q & ~hist_q;
    assign fall_seen = ~sync2_q & hist_q;
    assign hit       = pol_rise ? rise_seen : fall_seen;

endmodule

// File: rtl/tsc_cfg_regs.sv
module tsc_cfg_regs #(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 6,
    localparam int CFG_W  = CNT_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               alt_we,
    input  logic [FRAME_W-1:0] alt_wdata,
    output logic [CFG_W-1:0]   cfg_q,
    output logic [FRAME_W-1:0] alt_q,
    output logic               pol_rise,
    output logic               src_alt,
    output logic               chain_en,
    output logic [CNT_W-1:0]   chain_cnt
);
    import tsc_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && !busy) begin
            cfg_q <= cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q <= '0;
        end else if (alt_we) begin
            alt_q <= alt_wdata;
        end
    end

    assign pol_rise  = cfg_q[CFG_TPOL_BIT];
    assign src_alt   = cfg_q[CFG_SRC_BIT];
    assign chain_en  = cfg_q[CFG_CHAIN_BIT];
    assign chain_cnt = cfg_q[CFG_CNT_LSB +: CNT_W];

endmodule

// File: rtl/tsc_xfer_fsm.sv
module tsc_xfer_fsm #(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 6,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               chain_en,
    input  logic [CNT_W-1:0]   chain_cnt,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               cs_n,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_data
);
    import tsc_pkg::*;

    localparam logic [LEN_W-1:0] FRAME_LEN = LEN_W'(FRAME_W);
    localparam logic [LEN_W-1:0] ONE_LEN   = LEN_W'(1);

    tsc_state_e         state_q, state_d;
    logic [1:0]         ph_q;
    logic [LEN_W-1:0]   bit_q;
    logic [LEN_W-1:0]   len_q;
    logic [FRAME_W-1:0] shreg_q;

    // transfer length chosen at load time
    logic [LEN_W-1:0] cnt_plus1;
    logic [LEN_W-1:0] len_d;
    assign cnt_plus1 = {1'b0, chain_cnt} + ONE_LEN;

    always_comb begin
        if (!chain_en) begin
            len_d = FRAME_LEN;
        end else if (cnt_plus1 < FRAME_LEN) begin
            len_d = FRAME_LEN;
        end else begin
            len_d = cnt_plus1;
        end
    end

    logic last_bit;
    assign last_bit = (bit_q == (len_q - ONE_LEN));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (ph_q == 2'd1 && last_bit) state_d = ST_TRAIL;
            ST_TRAIL: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 2'd0;
            bit_q   <= '0;
            len_q   <= FRAME_LEN;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q <= load_word;
                        len_q   <= len_d;
                        bit_q   <= '0;
                        ph_q    <= 2'd0;
                    end
                end
                ST_SHIFT: begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd1) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], miso};
                        bit_q   <= bit_q + ONE_LEN;
                    end
                end
                ST_LEAD, ST_TRAIL, ST_DONE: begin
                    ph_q <= 2'd0;
                end
                default: begin
                    ph_q <= 2'd0;
                end
            endcase
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        sck  = 1'b0;
        cs_n = 1'b1;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_LEAD:  cs_n = 1'b0;
            ST_SHIFT: begin
                cs_n = 1'b0;
                sck  = ~ph_q[1];
            end
            ST_TRAIL: cs_n = 1'b0;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign mosi    = shreg_q[FRAME_W-1];
    assign rx_data = shreg_q;

endmodule

// File: rtl/trig_ser_ctrl.sv
module trig_ser_ctrl #(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_in,
    input  logic [FRAME_W-1:0]   par_in,
    input  logic                 alt_we,
    input  logic [FRAME_W-1:0]   alt_wdata,
    input  logic                 cfg_we,
    input  logic [CNT_W+2:0]     cfg_wdata,
    output logic [CNT_W+2:0]     cfg_rd,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 busy,
    output logic                 done,
    output logic [FRAME_W-1:0]   rx_data
);
    logic               pol_rise, src_alt, chain_en;
    logic [CNT_W-1:0]   chain_cnt;
    logic [FRAME_W-1:0] alt_q;
    logic               edge_hit;
    logic               start;
    logic [FRAME_W-1:0] load_word;

    tsc_cfg_regs #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .alt_we    (alt_we),
        .alt_wdata (alt_wdata),
        .cfg_q     (cfg_rd),
        .alt_q     (alt_q),
        .pol_rise  (pol_rise),
        .src_alt   (src_alt),
        .chain_en  (chain_en),
        .chain_cnt (chain_cnt)
    );

    tsc_trig_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .pol_rise (pol_rise),
        .hit      (edge_hit)
    );

    assign start     = edge_hit & ~busy;
    assign load_word = src_alt ? alt_q : par_in;

    tsc_xfer_fsm #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_word (load_word),
        .chain_en  (chain_en),
        .chain_cnt (chain_cnt),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data)
    );

endmodule

// File: rtl/trig_ser_ctrl_chk.sv
module trig_ser_ctrl_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CNT_W+2:0] cfg_rd,
    input logic             sck,
    input logic             cs_n,
    input logic             busy,
    input logic             done
);
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> $stable(cfg_rd));

    p_sck_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> sck);

    p_sck_inside_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    p_lead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> sck);

    p_trail_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sck));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    p_start_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !$past(busy));

endmodule

bind trig_ser_ctrl trig_ser_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .cfg_rd (cfg_rd),
    .sck    (sck),
    .cs_n   (cs_n),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_trig_ser_ctrl.sv
module sim_trig_ser_ctrl;
    localparam int FW    = 8;
    localparam int CW    = 6;
    localparam int CFG_W = CW + 3;

    localparam int M_PLAIN    = 0;
    localparam int M_MIDCFG   = 1;
    localparam int M_RETRIG   = 2;
    localparam int M_ALT_SAME = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic [FW-1:0] par_in = '0;
    logic alt_we = 1'b0;
    logic [FW-1:0] alt_wdata = '0;
    logic cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rd;
    logic sck, mosi, cs_n, busy, done;
    logic miso = 1'b0;
    logic [FW-1:0] rx_data;

    always #2 clk = ~clk;

    trig_ser_ctrl #(.FRAME_W(FW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .par_in(par_in),
        .alt_we(alt_we), .alt_wdata(alt_wdata), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy), .done(done), .rx_data(rx_data)
    );

    int checks = 0;
    int errors = 0;

    // serial-side monitor and slave model, all at the falling clock edge
    logic [63:0] miso_pat = '0;
    logic [63:0] mosi_cap;
    logic [FW-1:0] rx_cap;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;
    int n_rise = 0, ncyc = 0, cs_to_rise = -1, fall_mark = 0, fall_to_cs = -1;
    int miso_idx = 0, done_cnt = 0, done_w = 0, xfer_cnt = 0;

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            n_rise = 0; ncyc = 0; cs_to_rise = -1; miso_idx = 0;
            done_w = 0; xfer_cnt++;
            miso = miso_pat[0];
        end
        fall_mark++;
        if (sck && !prev_sck) begin
            if (n_rise == 0) cs_to_rise = ncyc;
            if (n_rise < 64) mosi_cap[n_rise] = mosi;
            n_rise++;
        end
        if (!sck && prev_sck) begin
            fall_mark = 0;
            miso_idx++;
            if (miso_idx < 64) miso = miso_pat[miso_idx];
        end
        if (!cs_n) ncyc++;
        if (cs_n && !prev_cs) fall_to_cs = fall_mark;
        if (done) begin
            done_cnt++; done_w++;
            rx_cap = rx_data;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic write_alt(input logic [FW-1:0] v);
        @(negedge clk); alt_we = 1'b1; alt_wdata = v;
        @(negedge clk); alt_we = 1'b0;
    endtask

    task automatic run_xfer(input logic tpol, input logic src, input logic chain,
                            input logic [CW-1:0] cnt, input logic [FW-1:0] par,
                            input logic [FW-1:0] alt, input logic [63:0] pat,
                            input int mode);
        logic [CFG_W-1:0] cv;
        logic [FW-1:0] word;
        logic [63:0] em, mask;
        logic [FW-1:0] erx;
        int n, d0, x0, t;
        cv = {cnt, chain, src, tpol};
        write_cfg(cv);
        chk("R1 cfg readback", cfg_rd, cv);
        write_alt(alt);
        par_in = par;
        miso_pat = pat;
        x0 = xfer_cnt;
        d0 = done_cnt;
        trig_in = ~tpol;
        repeat (6) @(negedge clk);
        chk("R3 opposite edge ignored", cs_n, 1'b1);
        trig_in = tpol;
        @(negedge clk);
        @(negedge clk);
        chk("R4 cs still high two edges after trigger", cs_n, 1'b1);
        if (mode == M_ALT_SAME) begin alt_we = 1'b1; alt_wdata = ~alt; end
        @(negedge clk);
        alt_we = 1'b0;
        chk("R4 cs low on third edge", cs_n, 1'b0);
        par_in = ~par;
        if (mode == M_MIDCFG) begin
            cfg_we = 1'b1; cfg_wdata = ~cv;
            @(negedge clk); cfg_we = 1'b0;
            chk("R2 write blocked while busy", cfg_rd, cv);
        end
        if (mode == M_RETRIG) begin
            trig_in = ~tpol;
            repeat (3) @(negedge clk);
            trig_in = tpol;
        end
        t = 0;
        while (done_cnt == d0 && t < 2000) begin @(negedge clk); t++; end
        if (done_cnt == d0) begin
            errors++; checks++;
            $display("FAIL R10 done never seen actual=0 expected=1");
        end
        repeat (20) @(negedge clk);
        chk("R11 one transfer per trigger", xfer_cnt - x0, 1);
        word = src ? alt : par;
        if (!chain) n = FW;
        else n = (int'(cnt) + 1 < FW) ? FW : int'(cnt) + 1;
        em = '0;
        for (int i = 0; i < n; i++) em[i] = (i < FW) ? word[FW-1-i] : pat[i-FW];
        mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        for (int j = 0; j < FW; j++) erx[FW-1-j] = pat[n-FW+j];
        chk(chain ? "R8 sck count" : "R7 sck count", n_rise, n);
        chk(chain ? "R8 mosi stream" : (src ? "R6 mosi word" : "R5 mosi snapshot"),
            mosi_cap & mask, em & mask);
        chk("R9 cs to first rise", cs_to_rise, 1);
        chk("R9 last fall to cs release", fall_to_cs, 1);
        chk("R10 done width", done_w, 1);
        chk("R10 rx word", rx_cap, erx);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", cfg_rd, '0);
        chk("R1 reset cs_n", cs_n, 1'b1);
        chk("R1 reset sck", sck, 1'b0);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset done", done, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // plain frames: both polarities, both sources, several words
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++) begin
                    logic [FW-1:0] pv, av;
                    pv = FW'(8'h3C ^ (k * 8'h51));
                    av = FW'(8'hC5 + (k * 8'h27));
                    run_xfer(p[0], s[0], 1'b0, '0, pv, av,
                             64'hA5C3_1E97_6B2D_F048 ^ {56'd0, 8'(k * 13)}, M_PLAIN);
                end

        // chained lengths, including counts below the frame size
        begin
            int cl [6] = '{3, 7, 8, 12, 20, 63};
            foreach (cl[i]) begin
                run_xfer(i[0], i[1], 1'b1, CW'(cl[i]), 8'h96, 8'h4B,
                         64'h0F1E_2D3C_4B5A_6978 ^ {32'd0, 32'(i * 32'h1357_9BDF)}, M_PLAIN);
            end
        end

        // blocked configuration write, re-trigger while busy, same-clock alt write
        run_xfer(1'b1, 1'b0, 1'b0, '0, 8'hE1, 8'h00, 64'h5555_AAAA_3333_CCCC, M_MIDCFG);
        run_xfer(1'b0, 1'b1, 1'b1, 6'd15, 8'h00, 8'h7E, 64'h1234_5678_9ABC_DEF0, M_RETRIG);
        run_xfer(1'b1, 1'b1, 1'b0, '0, 8'h00, 8'hB2, 64'hFEDC_BA98_7654_3210, M_ALT_SAME);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule